// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave side of a byte-wide serial memory. A bus master drives the SPI clock, the data input and an active-low select. The block shifts in an opcode, a two-byte address and any data bytes. Reads stream array bytes back on the output line and continue through the whole array. Write data is gathered in a page buffer. When the select is released after a whole number of data bytes, the page is handed to a write-control unit, which commits it after a configurable number of clock cycles and reports a busy flag until it is done. An active-low hold input lets the master pause a transfer at any point and resume it later.

The SPI pins are sampled by the system clock `clk_i` through synchronizers, so the master's SCK must run well below the system clock. Only SPI modes 0 and 3 are supported. The array is a register model of `2**MEM_ADDR_W` bytes: a full-size part uses 15 address bits (32768 bytes), and the default build uses a smaller array to keep elaboration light. Pages are `2**PAGE_W` bytes, 64 by default. After reset every array byte reads 0xFF.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `so_oe_o` and `busy_o` are low, the status byte reads 0x00, and every array byte reads 0xFF.
- R2: SI is sampled on rising SCK and SO changes on falling SCK, most significant bit first. `so_oe_o` stays low during opcode and address bytes and is high only while read data or status is being shifted out.
- R3: READ (0x03), then a 16-bit address (high byte first), returns bytes from consecutive addresses. Address bits above MEM_ADDR_W are ignored, and the address wraps from the last location to 0.
- R4: WREN (0x06) sets the write-enable bit, which is status bit 1. WRDI (0x04) clears it. A WRITE (0x02) sent while the bit is clear changes nothing and starts no write cycle.
- R5: Data bytes of a WRITE go to consecutive offsets inside the addressed page and wrap to the page start past its end. A later byte for the same offset replaces an earlier one, and bytes of the page that were not sent keep their old values.
- R6: A write cycle starts only when CS rises after one or more complete data bytes. A trailing partial byte, or a WRITE with no data bytes, leaves the array and the busy flag unchanged.
- R7: A write cycle holds `busy_o` and status bit 0 high for exactly WR_CYCLES clocks and clears the write-enable bit. During the cycle RDSR (0x05) still works and every other opcode is ignored until CS rises.
- R8: While HOLD is low with CS low, SCK and SI transitions are ignored and `so_oe_o` is low. After HOLD returns high, the transfer continues from the same bit.
- R9: CS high ends any transaction. The next CS low starts a fresh opcode, and any partial bits already received are dropped.
- R10: An unknown opcode makes the block ignore all following bytes until CS rises, and SO is not driven.
- R11: WRSR (0x01) with the write-enable bit set copies data bits 7:2 into status bits 7:2 and clears the write-enable bit. Without the write-enable bit set, WRSR has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock from the master |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data from the master |
| hold_ni | input | 1 | Active-low transfer pause |
| so_o | output | 1 | Serial data to the master |
| so_oe_o | output | 1 | Output enable for so_o (high = driven) |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that SCK is at least four system clocks high and four low, and that HOLD and CS change only while SCK is low. Under those conditions no synchronized SCK edge coincides with a select or hold edge, and a loaded output byte is always ready before the next falling edge. The bench's bit-level master toggles every line on falling system-clock edges, four clocks apart. It drops HOLD only with SCK low, toggles SCK and SI while held, and returns SCK low before it releases HOLD. It lets the write cycle finish before it checks contents. The stimulus uses random addresses, lengths and data, and adds directed cases for array wrap, page wrap, partial bytes, aborted selects and unknown opcodes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR_HI, ST_ADDR_LO, ST_RD, ST_WR, ST_RDSR, ST_WRSR, ST_SKIP
  } state_e;
endpackage

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic hold_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_act_o,
  output logic hold_act_o,
  output logic si_o
);
  // bit order: {hold_n, si, cs_n, sck}
  localparam logic [3:0] PIN_RST = 4'b1010;

  logic [3:0] pin;
  logic [3:0] stg_q [SYNC_STAGES];
  logic [3:0] cur;
  logic [1:0] last_q;

  assign pin = {hold_ni, si_i, cs_ni, sck_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= PIN_RST;
      last_q <= PIN_RST[1:0];
    end else begin
      stg_q[0] <= pin;
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
      last_q <= stg_q[SYNC_STAGES-1][1:0];
    end
  end

  assign cur        = stg_q[SYNC_STAGES-1];
  assign cs_act_o   = ~cur[1];
  assign hold_act_o = cs_act_o & ~cur[3];
  assign cs_fall_o  = ~cur[1] & last_q[1];
  assign cs_rise_o  = cur[1] & ~last_q[1];
  assign si_o       = cur[2];

  // clock edges only count inside an established, unheld select
  logic edge_ok;
  assign edge_ok    = cs_act_o & ~last_q[1] & ~hold_act_o;
  assign sck_rise_o = edge_ok & cur[0] & ~last_q[0];
  assign sck_fall_o = edge_ok & ~cur[0] & last_q[0];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int MEM_ADDR_W = 11,
  parameter int PAGE_W     = 6,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PG_W       = MEM_ADDR_W - PAGE_W,
  localparam int HI_W       = MEM_ADDR_W - 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sck_rise_i,
  input  logic                    sck_fall_i,
  input  logic                    cs_fall_i,
  input  logic                    cs_rise_i,
  input  logic                    cs_act_i,
  input  logic                    hold_act_i,
  input  logic                    si_i,
  input  logic                    busy_i,
  input  logic [7:0]              rd_data_i,
  output logic [MEM_ADDR_W-1:0]   rd_addr_o,
  output logic                    wr_req_o,
  output logic [PG_W-1:0]         wr_page_o,
  output logic [PAGE_BYTES*8-1:0] wr_data_o,
  output logic [PAGE_BYTES-1:0]   wr_mask_o,
  output logic                    so_o,
  output logic                    so_oe_o
);
  state_e state_q;
  logic [2:0]                    bit_cnt_q;
  logic [6:0]                    sh_q;
  logic [HI_W-1:0]               addr_hi_q;
  logic [MEM_ADDR_W-1:0]         addr_q;
  logic [PAGE_W-1:0]             off_q;
  logic [PG_W-1:0]               page_q;
  logic [PAGE_BYTES-1:0][7:0]    buf_q;
  logic [PAGE_BYTES-1:0]         mask_q;
  logic                          got_q, is_wr_q, wel_q, ld_q, so_q, oe_q, wr_req_q;
  logic [5:0]                    usr_q;
  logic [7:0]                    tx_q;

  logic [7:0]            rx_byte;
  logic [MEM_ADDR_W-1:0] addr_full;
  logic [7:0]            status;

  assign rx_byte   = {sh_q, si_i};
  assign addr_full = {addr_hi_q, rx_byte};
  assign status    = {usr_q, wel_q, busy_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      addr_hi_q <= '0;
      addr_q    <= '0;
      off_q     <= '0;
      page_q    <= '0;
      buf_q     <= '0;
      mask_q    <= '0;
      got_q     <= 1'b0;
      is_wr_q   <= 1'b0;
      wel_q     <= 1'b0;
      ld_q      <= 1'b0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
      wr_req_q  <= 1'b0;
      usr_q     <= '0;
      tx_q      <= '0;
    end else begin
      wr_req_q <= 1'b0;
      if (ld_q) begin
        ld_q <= 1'b0;
        if (state_q == ST_RD) begin
          tx_q   <= rd_data_i;
          addr_q <= addr_q + MEM_ADDR_W'(1);
        end else begin
          tx_q <= status;
        end
      end
      if (cs_fall_i) begin
        state_q   <= ST_CMD;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (cs_rise_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        if (state_q == ST_WR && bit_cnt_q == 3'd0 && got_q) begin
          wr_req_q <= 1'b1;
          wel_q    <= 1'b0;
        end
      end else begin
        if (sck_rise_i) begin
          sh_q      <= rx_byte[6:0];
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            unique case (state_q)
              ST_CMD: begin
                if (busy_i && rx_byte != OP_RDSR) state_q <= ST_SKIP;
                else begin
                  case (rx_byte)
                    OP_READ:  begin state_q <= ST_ADDR_HI; is_wr_q <= 1'b0; end
                    OP_WRITE: begin
                      state_q <= wel_q ? ST_ADDR_HI : ST_SKIP;
                      is_wr_q <= 1'b1;
                    end
                    OP_WREN:  begin wel_q <= 1'b1; state_q <= ST_SKIP; end
                    OP_WRDI:  begin wel_q <= 1'b0; state_q <= ST_SKIP; end
                    OP_RDSR:  begin state_q <= ST_RDSR; ld_q <= 1'b1; end
                    OP_WRSR:  state_q <= wel_q ? ST_WRSR : ST_SKIP;
                    default:  state_q <= ST_SKIP;
                  endcase
                end
              end
              ST_ADDR_HI: begin
                addr_hi_q <= rx_byte[HI_W-1:0];
                state_q   <= ST_ADDR_LO;
              end
              ST_ADDR_LO: begin
                addr_q <= addr_full;
                if (is_wr_q) begin
                  state_q <= ST_WR;
                  off_q   <= addr_full[PAGE_W-1:0];
                  page_q  <= addr_full[MEM_ADDR_W-1:PAGE_W];
                  mask_q  <= '0;
                  got_q   <= 1'b0;
                end else begin
                  state_q <= ST_RD;
                  ld_q    <= 1'b1;
                end
              end
              ST_WR: begin
                buf_q[off_q]  <= rx_byte;
                mask_q[off_q] <= 1'b1;
                off_q         <= off_q + PAGE_W'(1);
                got_q         <= 1'b1;
              end
              ST_WRSR: begin
                usr_q   <= rx_byte[7:2];
                wel_q   <= 1'b0;
                state_q <= ST_SKIP;
              end
              ST_RD, ST_RDSR: ld_q <= 1'b1;
              default: ;
            endcase
          end
        end
        if (sck_fall_i && (state_q == ST_RD || state_q == ST_RDSR)) begin
          so_q <= tx_q[7];
          tx_q <= {tx_q[6:0], 1'b0};
          oe_q <= 1'b1;
        end
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_req_o  = wr_req_q;
  assign wr_page_o = page_q;
  assign wr_data_o = buf_q;
  assign wr_mask_o = mask_q;
  assign so_o      = so_q;
  assign so_oe_o   = oe_q & cs_act_i & ~hold_act_i;

  assert_hold_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act_i && !cs_fall_i && !cs_rise_i) |=> ($stable(bit_cnt_q) && $stable(sh_q)));

  assert_busy_no_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !(state_q inside {ST_ADDR_HI, ST_ADDR_LO, ST_RD, ST_WR, ST_WRSR}));

  assert_cs_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> (state_q == ST_IDLE && bit_cnt_q == 3'd0 && !so_oe_o));

  assert_commit_clears_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !wel_q);
endmodule

// File: rtl/spi_mem_wctl.sv
module spi_mem_wctl #(
  parameter int MEM_ADDR_W = 11,
  parameter int PAGE_W     = 6,
  parameter int WR_CYCLES  = 2000,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PG_W       = MEM_ADDR_W - PAGE_W,
  localparam int MEM_BYTES  = 1 << MEM_ADDR_W,
  localparam int CNT_W      = $clog2(WR_CYCLES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [PG_W-1:0]         page_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [MEM_ADDR_W-1:0]   rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic                    busy_o
);
  logic [7:0]      mem_q [MEM_BYTES];
  logic            busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PG_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(WR_CYCLES - 1)) begin
        busy_q <= 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++)
          if (mask_i[i]) mem_q[{page_q, i[PAGE_W-1:0]}] <= data_i[i*8 +: 8];
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else if (req_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      page_q <= page_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;

  assert_req_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !busy_q);

  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == CNT_W'(WR_CYCLES - 1));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int MEM_ADDR_W  = 11,
  parameter int PAGE_W      = 6,
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PG_W       = MEM_ADDR_W - PAGE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o,
  output logic busy_o
);
  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act, hold_act, si_s;
  logic [MEM_ADDR_W-1:0]   rd_addr;
  logic [7:0]              rd_data;
  logic                    wr_req;
  logic [PG_W-1:0]         wr_page;
  logic [PAGE_BYTES*8-1:0] wr_data;
  logic [PAGE_BYTES-1:0]   wr_mask;

  spi_mem_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i, .hold_ni,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise), .cs_act_o(cs_act), .hold_act_o(hold_act), .si_o(si_s)
  );

  spi_mem_ctrl #(.MEM_ADDR_W(MEM_ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .cs_fall_i(cs_fall),
    .cs_rise_i(cs_rise), .cs_act_i(cs_act), .hold_act_i(hold_act), .si_i(si_s),
    .busy_i(busy_o), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_req_o(wr_req), .wr_page_o(wr_page), .wr_data_o(wr_data), .wr_mask_o(wr_mask),
    .so_o, .so_oe_o
  );

  spi_mem_wctl #(.MEM_ADDR_W(MEM_ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_wctl (
    .clk_i, .rst_ni, .req_i(wr_req), .page_i(wr_page), .data_i(wr_data),
    .mask_i(wr_mask), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o
  );
endmodule

// File: tb/spi_mem_slave_bench.sv
`timescale 1ns/1ps
module spi_mem_slave_bench;
  localparam int AW   = 11;
  localparam int WRC  = 2000;
  localparam int HALF = 4;
  localparam int MSZ  = 1 << AW;
  localparam int MASK = MSZ - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, busy;

  always #2.5 clk = ~clk;

  spi_mem_slave #(.MEM_ADDR_W(AW), .PAGE_W(6), .WR_CYCLES(WRC)) u_spi_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe), .busy_o(busy)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int busy_cycles = 0;
  logic [7:0] model [MSZ];
  logic [7:0] wbuf [128];
  logic [7:0] rbuf [128];
  logic [5:0] m_usr = '0;
  bit         m_wel = 1'b0;

  always @(negedge clk) if (busy) busy_cycles++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int paddr(input int base, input int k);
    return (base & ~63) | ((base + k) & 63);
  endfunction

  function automatic logic [7:0] st_exp(input bit b);
    return {m_usr, m_wel, b};
  endfunction

  task automatic xfer(input logic [7:0] tx, input bit do_hold, output logic [7:0] rx, output bit oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      clks(HALF);
      rx[i] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
      if (do_hold && i == 4) begin
        clks(HALF);
        hold_n = 1'b0;
        clks(HALF);
        check(so_oe == 1'b0, "R8 oe during hold", so_oe, 0);
        repeat (3) begin
          sck = 1'b1; si = ~si; clks(HALF);
          sck = 1'b0; clks(HALF);
        end
        hold_n = 1'b1;
        clks(HALF);
      end
    end
  endtask

  task automatic bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = v[i]; clks(HALF); sck = 1'b1; clks(HALF); sck = 1'b0;
    end
  endtask

  task automatic cs_start; cs_n = 1'b0; clks(HALF); endtask
  task automatic cs_end;   clks(HALF); cs_n = 1'b1; clks(2*HALF); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d; bit o;
    cs_start; xfer(op, 1'b0, d, o); cs_end;
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d; bit o;
    cs_start; xfer(8'h05, 1'b0, d, o); xfer(8'h00, 1'b0, st, o); cs_end;
  endtask

  // read n bytes; returns whether SO was driven in the header and in the data
  task automatic rd(input logic [15:0] a, input int n, input int hold_at, output bit hdr_oe, output bit dat_oe);
    logic [7:0] d; bit o;
    hdr_oe = 1'b0; dat_oe = 1'b0;
    cs_start;
    xfer(8'h03, 1'b0, d, o); hdr_oe |= o;
    xfer(a[15:8], 1'b0, d, o); hdr_oe |= o;
    xfer(a[7:0], 1'b0, d, o); hdr_oe |= o;
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, k == hold_at, rbuf[k], o);
      dat_oe |= o;
    end
    cs_end;
  endtask

  task automatic wr(input logic [15:0] a, input int n, input int extra);
    logic [7:0] d; bit o;
    cs_start;
    xfer(8'h02, 1'b0, d, o);
    xfer(a[15:8], 1'b0, d, o);
    xfer(a[7:0], 1'b0, d, o);
    for (int k = 0; k < n; k++) xfer(wbuf[k], 1'b0, d, o);
    if (extra > 0) bits(8'hA5, extra);
    cs_end;
  endtask

  task automatic wait_done;
    logic [7:0] st;
    for (int t = 0; t < 200; t++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic check_page(input int base, input string req, input int hold_at);
    bit h, dd; int bad = 0; int first = -1;
    rd(16'(base & ~63), 64, hold_at, h, dd);
    for (int k = 0; k < 64; k++)
      if (rbuf[k] !== model[(base & ~63) + k]) begin
        bad++; if (first < 0) first = k;
      end
    check(bad == 0, req, (first < 0) ? 0 : rbuf[first], (first < 0) ? 0 : model[(base & ~63) + first]);
  endtask

  initial begin
    logic [7:0] st;
    bit h, dd;
    int a, n, bad;
    void'($urandom(32'd4242));
    for (int i = 0; i < MSZ; i++) model[i] = 8'hFF;
    clks(5); rst_n = 1'b1; clks(5);

    check(so_oe == 1'b0 && busy == 1'b0, "R1 reset outputs", {so_oe, busy}, 0);
    rdsr(st);
    check(st == 8'h00, "R1 reset status", st, 8'h00);
    a = $urandom % MSZ;
    rd(16'(a), 4, -1, h, dd);
    bad = 0;
    for (int k = 0; k < 4; k++) if (rbuf[k] !== 8'hFF) bad++;
    check(bad == 0, "R1 erased array", rbuf[0], 8'hFF);
    check(h == 1'b0 && dd == 1'b1, "R2 oe only in data phase", {h, dd}, 2'b01);

    // write without enable
    a = $urandom % MSZ;
    for (int k = 0; k < 3; k++) wbuf[k] = 8'h3C + 8'(k);
    busy_cycles = 0;
    wr(16'(a), 3, 0);
    rdsr(st);
    check(st == 8'h00 && busy_cycles == 0, "R4 write without enable", st, 8'h00);
    check_page(a, "R4 array unchanged", -1);

    cmd1(8'h06); rdsr(st);
    check(st == 8'h02, "R4 WREN sets bit1 (R2 msb first)", st, 8'h02);
    cmd1(8'h04); rdsr(st);
    check(st == 8'h00, "R4 WRDI clears", st, 8'h00);

    // random page writes, directed ones at both ends of the array
    for (int it = 0; it < 6; it++) begin
      if (it == 0) begin a = MASK - 1; n = 2; end
      else if (it == 1) begin a = 0; n = 1; end
      else begin a = $urandom % MSZ; n = 1 + ($urandom % 72); end
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      cmd1(8'h06);
      busy_cycles = 0;
      wr(16'(a), n, 0);
      rdsr(st);
      check(st[1:0] == 2'b01, "R7 busy and enable cleared", st[1:0], 2'b01);
      rd(16'(a), 1, -1, h, dd);
      check(!h && !dd, "R7 read ignored while busy", {h, dd}, 0);
      cmd1(8'h06);
      wait_done;
      check(busy_cycles == WRC, "R7 busy length", busy_cycles, WRC);
      rdsr(st);
      check(st == st_exp(1'b0), "R7 WREN ignored while busy", st, st_exp(1'b0));
      for (int k = 0; k < n; k++) model[paddr(a, k)] = wbuf[k];
      check_page(a, (it[0]) ? "R5 R8 page content with hold" : "R5 page content",
                 (it[0]) ? int'($urandom % 64) : -1);
    end

    // partial trailing byte and empty write
    a = $urandom % MSZ;
    for (int k = 0; k < 3; k++) wbuf[k] = 8'h55;
    cmd1(8'h06);
    busy_cycles = 0;
    wr(16'(a), 3, 5);
    clks(10);
    check(busy_cycles == 0 && busy == 1'b0, "R6 partial byte no cycle", busy_cycles, 0);
    check_page(a, "R6 partial byte array unchanged", -1);
    wr(16'(a), 0, 0);
    clks(10);
    check(busy_cycles == 0, "R6 empty write no cycle", busy_cycles, 0);
    cmd1(8'h04);

    // array wrap with high address bits set
    rd(16'hFFFF, 3, -1, h, dd);
    check(rbuf[0] == model[MASK] && rbuf[1] == model[0] && rbuf[2] == model[1],
          "R3 wrap to 0", {rbuf[0], rbuf[1], rbuf[2]}, {model[MASK], model[0], model[1]});

    // unknown opcode
    begin
      logic [7:0] d; bit o, any;
      any = 1'b0;
      cs_start;
      xfer(8'hAB, 1'b0, d, o); any |= o;
      xfer(8'h03, 1'b0, d, o); any |= o;
      for (int k = 0; k < 3; k++) begin xfer(8'h00, 1'b0, d, o); any |= o; end
      cs_end;
      check(!any, "R10 unknown opcode silent", any, 0);
    end

    // aborted select mid byte
    cs_start; bits(8'h06, 5); cs_end;
    rdsr(st);
    check(st == st_exp(1'b0), "R9 partial bits dropped", st, st_exp(1'b0));
    cs_start; bits(8'h00, 3); cs_end;
    cmd1(8'h06);
    rdsr(st);
    m_wel = 1'b1;
    check(st == st_exp(1'b0), "R9 fresh opcode after abort", st, st_exp(1'b0));

    // status field writes
    begin
      logic [7:0] d; bit o;
      cs_start; xfer(8'h01, 1'b0, d, o); xfer(8'hA7, 1'b0, d, o); cs_end;
      m_usr = 6'h29; m_wel = 1'b0;
      rdsr(st);
      check(st == st_exp(1'b0), "R11 WRSR with enable", st, st_exp(1'b0));
      cs_start; xfer(8'h01, 1'b0, d, o); xfer(8'h5C, 1'b0, d, o); cs_end;
      rdsr(st);
      check(st == st_exp(1'b0), "R11 WRSR without enable", st, st_exp(1'b0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule